// File: doc/BRIEF.md
# Column time-delay-integration accumulator

This block sums, for a single pixel column, the digitized samples that several sensor rows take of the same scene line as that line moves across the array. Every sample has already been through the ADC, so the summation is purely digital. The ADC's full range is therefore kept, and no analog integrator can saturate. One adder serves all rows of the column in turn. Each row's sample arrives as a separate transaction. The adder adds it to the partial sum of the scene line that this row currently views.

Partial sums are kept per scene line in a circular slot store whose depth equals the active stage count. A line boundary does two things. It releases the oldest scene line's finished sum, which has now crossed every active stage. It then recycles that slot, cleared, for the scene line that is entering. In color mode the rows form repeating red, green, blue triples. Each color keeps its own partial sums, and three tagged results leave per line. A full chip places one instance per column.

Top module: `tdi_column_acc`

## Requirements
- R1: While reset is held, and after it is released, `sum_valid`, `sum_data` and `sum_color` are all zero until the first result is emitted.
- R2: In mono mode with N active stages, the sample from row r in line k (lines counted from the most recent flush, starting at 0) is added to scene line k−r. When `line_start` is high at clock edge t and k ≥ N, the sum of scene line k−N is driven with `sum_valid` high for the one cycle that follows edge t+2.
- R3: A sample whose stage index is N or more does not change any emitted sum. In mono mode the stage index is the row. In color mode it is the row divided by 3.
- R4: The stage count is taken from `stage_cfg` at each `line_start` and clamped to the range 1 to 129. A value of 0 acts as 1, and any value above 129 acts as 129.
- R5: In color mode, row r belongs to color r mod 3 (0 = red, 1 = green, 2 = blue) and to stage r/3, and N counts stages per color. Each color is summed separately. The three sums are emitted on consecutive cycles after edges t+2, t+3 and t+4, tagged 0, 1 and 2 in that order. Mono results carry tag 0.
- R6: If the clamped stage count or the mode differs from the active setting at a `line_start`, every partial sum is discarded. No result is emitted until N further line boundaries have passed after the flushing one.
- R7: The first `line_start` after reset always flushes, so no result appears at the first N line boundaries.
- R8: With 129 stages at full-scale 10-bit input, the emitted sum is the exact value 131967, with no wrap.
- R9: With one stage, each line's row-0 sample is emitted unchanged at the next line boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse that marks a line boundary |
| stage_cfg | input | 8 | Requested stage count, sampled at `line_start` |
| color_mode | input | 1 | 1 selects RGB triples, sampled at `line_start` |
| sample_valid | input | 1 | A row sample is present |
| sample_row | input | 9 | Row index of the sample |
| sample_data | input | 10 | Quantized sample value |
| sum_valid | output | 1 | One-cycle pulse with a completed scene-line sum |
| sum_data | output | 18 | Completed sum |
| sum_color | output | 2 | Color tag of the sum (0 R, 1 G, 2 B) |

## Verification
The assertions assume three things about the inputs. No sample arrives in the same cycle as `line_start` or in the four cycles after it. Each row delivers at most one sample per line. A line is long enough that the three color emissions are over before the next boundary. The bench drives each line the same way: a one-cycle boundary pulse, then four idle cycles, then one sample per row on consecutive cycles, then two idle cycles. This holds every run inside those rules, including with extra rows beyond the active stages.

// File: rtl/tdi_pkg.sv
package tdi_pkg;
  typedef enum logic [1:0] {
    CH_R = 2'd0,
    CH_G = 2'd1,
    CH_B = 2'd2
  } chan_t;

  localparam int unsigned CHANNELS = 3;
endpackage

// File: rtl/tdi_slot_mem.sv
// Simple dual-port store of partial sums with registered read (block-RAM style).
module tdi_slot_mem #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 387,
  parameter int unsigned AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/tdi_line_ctrl.sv
// Latches configuration at line boundaries, tracks the circular slot pointer,
// the fill level since the last flush, and sequences the per-color emits.
module tdi_line_ctrl
  import tdi_pkg::*;
#(
  parameter int unsigned MAX_STAGES = 129,
  parameter int unsigned STG_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             sample_valid,
  input  logic [STG_W-1:0] stage_cfg,
  input  logic             color_mode,
  output logic [STG_W-1:0] n_act,
  output logic             color_act,
  output logic [STG_W-1:0] ptr,
  output logic             emit_go,
  output chan_t            emit_chan,
  output logic             emit_live
);
  localparam logic [STG_W-1:0] N_MAX = STG_W'(MAX_STAGES);
  localparam logic [STG_W-1:0] N_MIN = STG_W'(1);

  logic [STG_W-1:0] n_req;
  logic [STG_W-1:0] fill;
  logic             primed;
  logic             flush;
  logic             busy;
  chan_t            ech;
  logic             live;
  logic [2:0]       since;

  always_comb begin
    if (stage_cfg == '0)        n_req = N_MIN;
    else if (stage_cfg > N_MAX) n_req = N_MAX;
    else                        n_req = stage_cfg;
    flush = !primed || (n_req != n_act) || (color_mode != color_act);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_act     <= N_MIN;
      color_act <= 1'b0;
      ptr       <= '0;
      fill      <= '0;
      primed    <= 1'b0;
      busy      <= 1'b0;
      ech       <= CH_R;
      live      <= 1'b0;
      since     <= '1;
    end else if (line_start) begin
      primed    <= 1'b1;
      n_act     <= n_req;
      color_act <= color_mode;
      since     <= '0;
      busy      <= 1'b1;
      ech       <= CH_R;
      if (flush) begin
        ptr  <= '0;
        fill <= N_MIN;
        live <= 1'b0;
      end else begin
        ptr  <= (ptr == n_act - N_MIN) ? '0 : ptr + N_MIN;
        live <= (fill == n_act);
        fill <= (fill == n_act) ? fill : fill + N_MIN;
      end
    end else begin
      if (since != '1) since <= since + 3'd1;
      if (busy) begin
        if (!color_act || ech == CH_B) busy <= 1'b0;
        else                           ech  <= chan_t'(ech + 2'd1);
      end
    end
  end

  assign emit_go   = busy;
  assign emit_chan = ech;
  assign emit_live = live;

  assert_stage_range_R4: assert property (@(posedge clk) disable iff (rst)
    (n_act >= N_MIN) && (n_act <= N_MAX));

  assert_ptr_bound_R2: assert property (@(posedge clk) disable iff (rst)
    ptr < n_act);

  // R2: input rule, samples stay clear of the boundary and the emit window
  assert_sample_gap_R2: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (!line_start && since >= 3'd4));
endmodule

// File: rtl/tdi_column_acc.sv
module tdi_column_acc
  import tdi_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 10,
  parameter int unsigned SUM_W      = 18,
  parameter int unsigned MAX_STAGES = 129,
  parameter int unsigned STG_W      = 8,
  parameter int unsigned ROW_W      = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                line_start,
  input  logic [STG_W-1:0]    stage_cfg,
  input  logic                color_mode,
  input  logic                sample_valid,
  input  logic [ROW_W-1:0]    sample_row,
  input  logic [SAMPLE_W-1:0] sample_data,
  output logic                sum_valid,
  output logic [SUM_W-1:0]    sum_data,
  output logic [1:0]          sum_color
);
  localparam int unsigned DEPTH = CHANNELS * MAX_STAGES;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned CW    = ((ROW_W > STG_W) ? ROW_W : STG_W) + 1;

  logic [STG_W-1:0] n_act;
  logic             color_act;
  logic [STG_W-1:0] ptr;
  logic             emit_go;
  chan_t            emit_chan;
  logic             emit_live;

  tdi_line_ctrl #(.MAX_STAGES(MAX_STAGES), .STG_W(STG_W)) u_ctrl (
    .clk(clk), .rst(rst), .line_start(line_start), .sample_valid(sample_valid),
    .stage_cfg(stage_cfg), .color_mode(color_mode), .n_act(n_act),
    .color_act(color_act), .ptr(ptr), .emit_go(emit_go),
    .emit_chan(emit_chan), .emit_live(emit_live)
  );

  // Row decode: stage index and color of the incoming sample
  logic [CW-1:0] s_idx, n_w, p_w, slot;
  chan_t         s_chan;
  logic          in_range;
  logic [AW-1:0] samp_addr, emit_addr, raddr;

  always_comb begin
    n_w = CW'(n_act);
    p_w = CW'(ptr);
    if (color_act) begin
      s_idx  = CW'(sample_row / ROW_W'(3));
      s_chan = chan_t'(2'(sample_row % ROW_W'(3)));
    end else begin
      s_idx  = CW'(sample_row);
      s_chan = CH_R;
    end
    in_range  = s_idx < n_w;
    slot      = (p_w >= s_idx) ? (p_w - s_idx) : (p_w + n_w - s_idx);
    samp_addr = AW'(32'(s_chan) * MAX_STAGES + 32'(slot));
    emit_addr = AW'(32'(emit_chan) * MAX_STAGES + 32'(ptr));
    raddr     = emit_go ? emit_addr : samp_addr;
  end

  // Read stage
  logic                a_acc, a_emit, a_live;
  logic [AW-1:0]       a_addr;
  chan_t               a_chan;
  logic [SAMPLE_W-1:0] a_samp;
  logic [SUM_W-1:0]    rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_acc  <= 1'b0;
      a_emit <= 1'b0;
      a_live <= 1'b0;
      a_addr <= '0;
      a_chan <= CH_R;
      a_samp <= '0;
    end else begin
      a_acc  <= sample_valid && in_range && !emit_go;
      a_emit <= emit_go;
      a_live <= emit_live;
      a_addr <= raddr;
      a_chan <= emit_chan;
      a_samp <= sample_data;
    end
  end

  // Update stage: shared adder, or clear on emit
  logic             we;
  logic [SUM_W-1:0] wdata;

  always_comb begin
    we    = a_acc || a_emit;
    wdata = a_emit ? '0 : rdata + SUM_W'(a_samp);
  end

  tdi_slot_mem #(.W(SUM_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(we), .waddr(a_addr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_valid <= 1'b0;
      sum_data  <= '0;
      sum_color <= '0;
    end else begin
      sum_valid <= a_emit && a_live;
      if (a_emit && a_live) begin
        sum_data  <= rdata;
        sum_color <= a_chan;
      end
    end
  end

  assert_mono_tag_R5: assert property (@(posedge clk) disable iff (rst)
    (sum_valid && !color_act) |-> (sum_color == 2'd0));

  assert_color_order_R5: assert property (@(posedge clk) disable iff (rst)
    (sum_valid && $past(sum_valid)) |-> (sum_color == $past(sum_color) + 2'd1));

  assert_tag_range_R5: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> (sum_color != 2'd3));
endmodule

// File: tb/tdi_column_acc_test.sv
module tdi_column_acc_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_start = 1'b0;
  logic [7:0] stage_cfg = 8'd1;
  logic       color_mode = 1'b0;
  logic       sample_valid = 1'b0;
  logic [8:0] sample_row = '0;
  logic [9:0] sample_data = '0;
  logic        sum_valid;
  logic [17:0] sum_data;
  logic [1:0]  sum_color;

  tdi_column_acc uut (
    .clk(clk), .rst(rst), .line_start(line_start), .stage_cfg(stage_cfg),
    .color_mode(color_mode), .sample_valid(sample_valid), .sample_row(sample_row),
    .sample_data(sample_data), .sum_valid(sum_valid), .sum_data(sum_data),
    .sum_color(sum_color)
  );

  always #4 clk = ~clk;

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  // reference model state
  int    acc [longint];
  int    qd[$], qc[$], qv[$];
  string qt[$];
  int    kk = 0;
  int    prevN = 0;
  int    prevCol = 0;
  bit    primed = 1'b0;
  int    cfg = 1;
  int    colm = 0;
  string cur_tag = "R2";

  always @(posedge clk) cyc <= cyc + 1;

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (qd.size() > 0 && qd[0] <= cyc) begin
        if (!sum_valid || sum_data != 18'(qv[0]) || sum_color != 2'(qc[0]) || qd[0] != cyc) begin
          bad++;
          $display("FAIL %s cyc=%0d actual valid=%0b data=%0d color=%0d expected data=%0d color=%0d",
                   qt[0], cyc, sum_valid, sum_data, sum_color, qv[0], qc[0]);
        end
        void'(qd.pop_front()); void'(qc.pop_front());
        void'(qv.pop_front()); void'(qt.pop_front());
      end else if (sum_valid) begin
        bad++;
        $display("FAIL R6/R7 cyc=%0d actual valid=1 data=%0d expected valid=0", cyc, sum_data);
      end
    end
  end

  task automatic do_line(input int rows, input bit full_scale);
    int  n;
    bit  flush;
    int  c0;
    @(posedge clk); #1;
    c0 = cyc;
    n = (cfg == 0) ? 1 : ((cfg > 129) ? 129 : cfg);
    flush = !primed || n != prevN || colm != prevCol;
    primed = 1'b1; prevN = n; prevCol = colm;
    line_start = 1'b1; stage_cfg = 8'(cfg); color_mode = colm[0];
    if (flush) begin kk = 0; acc.delete(); end
    if (kk >= n) begin
      for (int ch = 0; ch < (colm ? 3 : 1); ch++) begin
        longint key = longint'(kk - n) * 4 + ch;
        qd.push_back(c0 + 3 + ch); qc.push_back(ch);
        qv.push_back(acc.exists(key) ? acc[key] : 0); qt.push_back(cur_tag);
        if (acc.exists(key)) acc.delete(key);
      end
    end
    @(posedge clk); #1;
    line_start = 1'b0;
    repeat (4) @(posedge clk); #1;
    for (int r = 0; r < rows; r++) begin
      int d = full_scale ? 1023 : int'($urandom_range(1023));
      int s = colm ? r / 3 : r;
      int ch = colm ? r % 3 : 0;
      sample_valid = 1'b1; sample_row = 9'(r); sample_data = 10'(d);
      if (s < n) begin   // R3: rows beyond the active stages contribute nothing
        longint key = longint'(kk - s) * 4 + ch;
        acc[key] = (acc.exists(key) ? acc[key] : 0) + d;
      end
      @(posedge clk); #1;
    end
    sample_valid = 1'b0;
    repeat (2) @(posedge clk);
    kk++;
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    // R1: reset state
    total++;
    if (sum_valid !== 1'b0 || sum_data !== 18'd0 || sum_color !== 2'd0) begin
      bad++;
      $display("FAIL R1 actual valid=%0b data=%0d color=%0d expected 0 0 0",
               sum_valid, sum_data, sum_color);
    end
    rst = 1'b0;
    @(posedge clk); #1;
    total++;
    if (sum_valid !== 1'b0 || sum_data !== 18'd0) begin
      bad++;
      $display("FAIL R1 after release actual valid=%0b data=%0d expected 0 0", sum_valid, sum_data);
    end
    // R2, R3, R7: mono, 4 stages, two extra rows beyond the stages
    cur_tag = "R3"; cfg = 4; colm = 0;
    for (int i = 0; i < 12; i++) do_line(6, 1'b0);
    // R9, R6: single stage
    cur_tag = "R9"; cfg = 1;
    for (int i = 0; i < 5; i++) do_line(3, 1'b0);
    // R4: 0 clamps to 1, same as active, so results continue without a flush
    cur_tag = "R4"; cfg = 0;
    for (int i = 0; i < 4; i++) do_line(2, 1'b0);
    // R5, R6: color mode, 3 stages per color, two spare rows
    cur_tag = "R5"; cfg = 3; colm = 1;
    for (int i = 0; i < 9; i++) do_line(11, 1'b0);
    // R2: back to mono after a mode change
    cur_tag = "R2"; cfg = 3; colm = 0;
    for (int i = 0; i < 7; i++) do_line(5, 1'b0);
    // R8, R4: 200 clamps to 129, full-scale input
    cur_tag = "R8"; cfg = 200;
    for (int i = 0; i < 133; i++) do_line(129, 1'b1);
    repeat (8) @(posedge clk);
    #1;
    if (qd.size() != 0) begin
      bad++; total++;
      $display("FAIL R2 actual pending=%0d expected pending=0", qd.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1400000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule